// File: doc/BRIEF.md
# Converter Soft-Start Sequencer

This block produces the digital soft-start ramp for a switching regulator. It counts switching-clock cycles, and its code stands in for the regulation reference until it reaches full scale. Every milestone is a clock count. The start-up time therefore follows the oscillator frequency: a slower switching clock gives a longer soft start.

The ramp is released only when three conditions hold: the bias supply reports above its lockout threshold, the enable input is high after synchronization, and no feedback-pin short is reported. Three milestone flags are decoded from the ramp:
- A synchronous-rectification permit at 95 % of the reference, so the converter can start into a pre-biased output.
- An in-regulation flag when the ramp equals the reference.
- A fault-arm flag at the 1.0 V-equivalent level, which stays high for the rest of the run.

Losing the supply or dropping the enable discharges everything, and the sequence then starts again from zero.

Top module: `softstart_seq`

## Requirements
- R1: While `rst` is sampled high at a clock edge, `ramp_o`, `sync_rect_o`, `in_reg_o` and `fault_arm_o` are all 0 after that edge.
- R2: The ramp stays at 0 unless `uvlo_ok_i` and the synchronized enable are both high. `en_i` passes through two flops, so with `uvlo_ok_i` already high and no short reported, `ramp_o` becomes 1 at the fourth rising edge after `en_i` is first sampled high.
- R3: While the block waits for release, a high `fb_short_i` holds `ramp_o` at 0 for as long as it stays high. After release, `fb_short_i` has no effect on the ramp.
- R4: After release, `ramp_o` rises by exactly one per clock and saturates at 4000.
- R5: `sync_rect_o` is high exactly when `ramp_o` is 3040 or more.
- R6: `in_reg_o` is high exactly when `ramp_o` is 3200 or more. It is never high while `sync_rect_o` is low.
- R7: `fault_arm_o` rises in the cycle in which `ramp_o` reaches 4000. It then stays high until the run is cleared.
- R8: When `uvlo_ok_i` is sampled low, `ramp_o` and all three flags are 0 after that same edge.
- R9: When the synchronized enable goes low, the ramp and flags clear one edge later. Raising `en_i` again restarts the ramp from 0 with the R2 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock |
| rst | input | 1 | Synchronous active-high reset |
| uvlo_ok_i | input | 1 | Bias supply above lockout threshold (already synchronous) |
| en_i | input | 1 | Asynchronous enable, synchronized internally |
| fb_short_i | input | 1 | Feedback-pin short detected |
| ramp_o | output | 12 | Soft-start ramp code |
| sync_rect_o | output | 1 | Full synchronous rectification permitted |
| in_reg_o | output | 1 | Ramp has reached the reference level |
| fault_arm_o | output | 1 | Fault latch armed |

## Verification
The hardest cases to reach are the two ends of a full ramp: the flag edges at counts 3039/3040, 3199/3200 and 3999/4000, and a discharge that happens while all three flags are high. The bench drives complete ramps of more than 4000 clocks. From the release edge it computes the exact cycle of each threshold and queues the expected value for the cycle on each side of it. It then drops the enable on a saturated ramp and expects the full-to-zero transition exactly three edges after the drop. A short reported after release is checked against a ramp value that keeps counting.

// File: rtl/softstart_pkg.sv
package softstart_pkg;

  typedef enum logic {
    GATE_WAIT = 1'b0,
    GATE_RUN  = 1'b1
  } gate_state_e;

  typedef struct packed {
    logic sync_rect;
    logic in_reg;
    logic fault_arm;
  } milestone_t;

endpackage

// File: rtl/ss_en_sync.sv
module ss_en_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ss_gate.sv
module ss_gate
  import softstart_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run_ok_i,
  input  logic fb_short_i,
  output logic release_o
);
  gate_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GATE_WAIT: if (run_ok_i && !fb_short_i) state_d = GATE_RUN;
      GATE_RUN:  if (!run_ok_i)               state_d = GATE_WAIT;
      default:                                state_d = GATE_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= GATE_WAIT;
    else     state_q <= state_d;
  end

  assign release_o = (state_q == GATE_RUN);
endmodule

// File: rtl/ss_ramp.sv
module ss_ramp #(
  parameter int CODE_W   = 12,
  parameter int FULL_CNT = 4000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              run_i,
  output logic [CODE_W-1:0] cnt_next_o,
  output logic [CODE_W-1:0] cnt_o
);
  localparam logic [CODE_W-1:0] FULL = CODE_W'(FULL_CNT);

  logic [CODE_W-1:0] cnt_q;

  always_comb begin
    if (clr_i)                       cnt_next_o = '0;
    else if (run_i && cnt_q < FULL)  cnt_next_o = cnt_q + 1'b1;
    else                             cnt_next_o = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_next_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ss_milestones.sv
module ss_milestones
  import softstart_pkg::*;
#(
  parameter int CODE_W   = 12,
  parameter int FULL_CNT = 4000,
  parameter int SREC_CNT = 3040,
  parameter int REG_CNT  = 3200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic [CODE_W-1:0] cnt_next_i,
  output milestone_t        flags_o
);
  localparam int NLVL = 2;
  localparam logic [CODE_W-1:0] FULL = CODE_W'(FULL_CNT);

  logic [NLVL-1:0] lvl_q;
  logic            arm_q;

  generate
    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
      localparam logic [CODE_W-1:0] THR = CODE_W'((g == 0) ? SREC_CNT : REG_CNT);
      always_ff @(posedge clk) begin
        if (rst || clr_i) lvl_q[g] <= 1'b0;
        else              lvl_q[g] <= (cnt_next_i >= THR);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr_i) arm_q <= 1'b0;
    else              arm_q <= arm_q | (cnt_next_i >= FULL);
  end

  assign flags_o.sync_rect = lvl_q[0];
  assign flags_o.in_reg    = lvl_q[1];
  assign flags_o.fault_arm = arm_q;
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import softstart_pkg::*;
#(
  parameter int CODE_W      = 12,
  parameter int FULL_CNT    = 4000,
  parameter int SREC_CNT    = 3040,
  parameter int REG_CNT     = 3200,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              uvlo_ok_i,
  input  logic              en_i,
  input  logic              fb_short_i,
  output logic [CODE_W-1:0] ramp_o,
  output logic              sync_rect_o,
  output logic              in_reg_o,
  output logic              fault_arm_o
);
  logic              en_s;
  logic              run_ok;
  logic              released;
  logic [CODE_W-1:0] cnt_next;
  milestone_t        flags;

  ss_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (en_i),
    .q_o (en_s)
  );

  assign run_ok = uvlo_ok_i & en_s;

  ss_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .run_ok_i   (run_ok),
    .fb_short_i (fb_short_i),
    .release_o  (released)
  );

  ss_ramp #(.CODE_W(CODE_W), .FULL_CNT(FULL_CNT)) u_ramp (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (!run_ok),
    .run_i      (released),
    .cnt_next_o (cnt_next),
    .cnt_o      (ramp_o)
  );

  ss_milestones #(
    .CODE_W(CODE_W), .FULL_CNT(FULL_CNT),
    .SREC_CNT(SREC_CNT), .REG_CNT(REG_CNT)
  ) u_miles (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (!run_ok),
    .cnt_next_i (cnt_next),
    .flags_o    (flags)
  );

  assign sync_rect_o = flags.sync_rect;
  assign in_reg_o    = flags.in_reg;
  assign fault_arm_o = flags.fault_arm;
endmodule

// File: rtl/softstart_seq_chk.sv
module softstart_seq_chk #(
  parameter int CODE_W   = 12,
  parameter int FULL_CNT = 4000
) (
  input logic              clk,
  input logic              rst,
  input logic              uvlo_ok_i,
  input logic [CODE_W-1:0] ramp_o,
  input logic              sync_rect_o,
  input logic              in_reg_o,
  input logic              fault_arm_o
);
  localparam logic [CODE_W-1:0] FULL = CODE_W'(FULL_CNT);

  // R4
  ramp_le_full_chk: assert property (@(posedge clk) disable iff (rst)
    ramp_o <= FULL);

  // R4
  ramp_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ramp_o == $past(ramp_o) || ramp_o == $past(ramp_o) + 1'b1 || ramp_o == '0));

  // R6
  reg_implies_srec_chk: assert property (@(posedge clk) disable iff (rst)
    in_reg_o |-> sync_rect_o);

  // R7
  fault_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_arm_o) |-> ramp_o == FULL);

  // R7
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fault_arm_o |=> (fault_arm_o || ramp_o == '0));

  // R8
  uvlo_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !uvlo_ok_i |=> (ramp_o == '0 && !sync_rect_o && !in_reg_o && !fault_arm_o));
endmodule

bind softstart_seq softstart_seq_chk #(.CODE_W(CODE_W), .FULL_CNT(FULL_CNT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .uvlo_ok_i   (uvlo_ok_i),
  .ramp_o      (ramp_o),
  .sync_rect_o (sync_rect_o),
  .in_reg_o    (in_reg_o),
  .fault_arm_o (fault_arm_o)
);

// File: tb/test_softstart_seq.sv
module test_softstart_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        uvlo_ok = 1'b0;
  logic        en = 1'b0;
  logic        fb_short = 1'b0;
  logic [11:0] ramp;
  logic        srec, inreg, farm;

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    int    at;
    int    ramp;
    bit    sr;
    bit    rg;
    bit    fa;
    string req;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  softstart_seq i_softstart_seq (
    .clk(clk), .rst(rst), .uvlo_ok_i(uvlo_ok), .en_i(en), .fb_short_i(fb_short),
    .ramp_o(ramp), .sync_rect_o(srec), .in_reg_o(inreg), .fault_arm_o(farm)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int at, int r, bit sr, bit rg, bit fa, string req);
    exp_t e;
    e.at = at; e.ramp = r; e.sr = sr; e.rg = rg; e.fa = fa; e.req = req;
    sb.push_back(e);
  endtask

  task automatic wait_until(int at);
    while (cyc < at) @(negedge clk);
  endtask

  // monitor: compare queued expectations at their cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      n_run++;
      if (e.at != cyc || int'(ramp) != e.ramp || srec != e.sr || inreg != e.rg || farm != e.fa) begin
        n_fail++;
        $display("FAIL %s cyc=%0d: ramp=%0d sr=%0b rg=%0b fa=%0b expected cyc=%0d ramp=%0d sr=%0b rg=%0b fa=%0b",
                 e.req, cyc, ramp, srec, inreg, farm, e.at, e.ramp, e.sr, e.rg, e.fa);
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int b, e0, d, g;
    repeat (3) @(negedge clk);
    // R1: reset state
    expect_at(cyc + 1, 0, 0, 0, 0, "R1");
    wait_until(cyc + 2);
    rst = 1'b0;

    // R3: short reported while waiting holds ramp at zero
    uvlo_ok = 1'b1; en = 1'b1; fb_short = 1'b1;
    b = cyc;
    expect_at(b + 10, 0, 0, 0, 0, "R3");
    expect_at(b + 60, 0, 0, 0, 0, "R3");
    wait_until(b + 61);

    // short clears: release next edge, count n at base+n
    fb_short = 1'b0;
    b = cyc + 1;
    expect_at(b, 0, 0, 0, 0, "R3");
    expect_at(b + 1, 1, 0, 0, 0, "R4");
    expect_at(b + 19, 19, 0, 0, 0, "R3");
    expect_at(b + 3039, 3039, 0, 0, 0, "R5");
    expect_at(b + 3040, 3040, 1, 0, 0, "R5");
    expect_at(b + 3199, 3199, 1, 0, 0, "R6");
    expect_at(b + 3200, 3200, 1, 1, 0, "R6");
    expect_at(b + 3999, 3999, 1, 1, 0, "R7");
    expect_at(b + 4000, 4000, 1, 1, 1, "R7");
    expect_at(b + 4100, 4000, 1, 1, 1, "R4");
    wait_until(b + 5);
    fb_short = 1'b1;   // after release: no effect (R3)
    wait_until(b + 4101);

    // R8: supply loss clears at the next edge
    uvlo_ok = 1'b0; fb_short = 1'b0;
    expect_at(cyc + 1, 0, 0, 0, 0, "R8");
    expect_at(cyc + 5, 0, 0, 0, 0, "R8");
    wait_until(cyc + 6);

    // R2: supply back but enable low -> no start
    en = 1'b0;
    wait_until(cyc + 5);
    uvlo_ok = 1'b1;
    expect_at(cyc + 10, 0, 0, 0, 0, "R2");
    wait_until(cyc + 11);

    // R2: enable rises, ramp=1 at fourth edge
    en = 1'b1;
    e0 = cyc;
    expect_at(e0 + 3, 0, 0, 0, 0, "R2");
    expect_at(e0 + 4, 1, 0, 0, 0, "R2");
    expect_at(e0 + 503, 500, 0, 0, 0, "R4");
    expect_at(e0 + 4010, 4000, 1, 1, 1, "R7");
    wait_until(e0 + 4020);

    // R9: enable drop on a saturated ramp
    en = 1'b0;
    d = cyc;
    expect_at(d + 2, 4000, 1, 1, 1, "R9");
    expect_at(d + 3, 0, 0, 0, 0, "R9");
    wait_until(d + 8);

    // R9: restart from zero
    en = 1'b1;
    g = cyc;
    expect_at(g + 4, 1, 0, 0, 0, "R9");
    expect_at(g + 13, 10, 0, 0, 0, "R9");
    wait_until(g + 16);

    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: pending=%0d expected=0", sb.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule